// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Front End

This block is the digital front end of a four-channel, 16-bit digital-to-analog converter. A host shifts a data word in over a three-wire serial link (serial clock, serial data, active-low select). A falling edge on the load strobe puts that word into the staging register of one channel, picked by a two-bit address. The converter outputs do not move at that point. A rising edge on the update strobe then copies all four staging registers into the four output registers in the same cycle, so every channel changes together.

Every pin is brought into one system clock domain through a synchronizer, and all edges are found there. A rising edge on the preset pin forces every staging and output register to a known code. A level pin picks that code: zero-scale or mid-scale. A preset edge wins over any load or update seen in the same cycle. The four output registers leave the block as one packed bus, which feeds the converter cores.

Top module: `dacif_top`

## Requirements
- R1: After the system reset (rst_n low), every channel of dac_out reads 16'h0000. Channel k sits at bits [16k+15:16k].
- R2: While ser_sel_n is low, each rising edge of ser_clk shifts ser_din into the serial word, most significant bit first. When more than 16 bits are sent, only the last 16 are kept.
- R3: Rising edges of ser_clk while ser_sel_n is high leave the serial word unchanged.
- R4: A falling edge of ld_n while ser_sel_n is low writes the serial word into the staging register of the channel on addr (0 = channel 0, 1 = channel 1, 2 = channel 2, 3 = channel 3). dac_out does not change.
- R5: A rising edge of upd while ser_sel_n is high and ld_n is high copies all four staging registers into dac_out in one cycle.
- R6: A rising edge of upd while ser_sel_n is low, or while ld_n is low, leaves dac_out unchanged.
- R7: While upd is held high after its rising edge, new staging writes do not reach dac_out until the next rising edge of upd.
- R8: A rising edge of preset while preset_mid is low sets every staging and output register to 16'h0000.
- R9: A rising edge of preset while preset_mid is high sets every staging and output register to 16'h8000.
- R10: When the rising edges of preset and upd fall in the same cycle, the preset code wins on every output.
- R11: A falling edge of ld_n while ser_sel_n is high writes no staging register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every other pin |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| ser_sel_n | input | 1 | Active-low serial select |
| addr | input | 2 | Channel picked for a staging write |
| ld_n | input | 1 | Staging load strobe; acts on its falling edge |
| upd | input | 1 | Global update strobe; acts on its rising edge |
| preset | input | 1 | Preset strobe; acts on its rising edge |
| preset_mid | input | 1 | Preset code select: 0 zero-scale, 1 mid-scale |
| dac_out | output | 64 | Four output registers, channel k at [16k+15:16k] |

## Verification
The main path is swept over every channel address with several arithmetic word patterns: walking ones, their complements and an XOR mix that differs per channel. A wrong address decode or a crossed lane shows up as a value in the wrong channel. Outputs are checked between load and update to tell single buffering apart from double buffering. Over-long words and clock edges sent while deselected separate a correct shift window from a wrong one. Update strobes with select low, with load low and with upd held high each show whether the strobe is qualified correctly. Presets in both modes, and a preset that lands together with an update, show which one has priority.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int WORD_W   = 16;
  localparam int NUM_CH   = 4;
  localparam int ADDR_W   = $clog2(NUM_CH);
  localparam int SYNC_LEN = 2;

  // positions inside the synchronized pin vector
  localparam int P_SCLK  = 0;
  localparam int P_DIN   = 1;
  localparam int P_SEL   = 2;
  localparam int P_LD    = 3;
  localparam int P_UPD   = 4;
  localparam int P_PRE   = 5;
  localparam int P_MID   = 6;
  localparam int P_ADDR  = 7;
  localparam int PIN_W   = P_ADDR + ADDR_W;

  typedef logic [WORD_W-1:0] word_t;

  // preset code: mid-scale is the top bit alone
  function automatic word_t preset_code(input logic mid);
    word_t c;
    c = '0;
    if (mid) c[WORD_W-1] = 1'b1;
    return c;
  endfunction

  // one-hot channel decode of an address
  function automatic logic [NUM_CH-1:0] ch_decode(input logic [ADDR_W-1:0] a);
    logic [NUM_CH-1:0] v;
    v = '0;
    v[a] = 1'b1;
    return v;
  endfunction

  // next serial word after one bit enters at the bottom
  function automatic word_t shift_in(input word_t w, input logic b);
    return {w[WORD_W-2:0], b};
  endfunction
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dacif_shift.sv
module dacif_shift
  import dacif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_en,
  input  logic  bit_in,
  output word_t word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= shift_in(word_q, bit_in);
  end

  // R3: without a shift pulse the serial word holds
  a_r3_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));
  // R2: a shift moves the word up by one and takes the new bit at the bottom
  a_r2_shift_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0]))
                 && (word_q[0] == $past(bit_in)));
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
  import dacif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pre_go,
  input  word_t pre_val,
  input  logic  wr_en,
  input  word_t wr_data,
  input  logic  upd_go,
  output word_t dac_q
);
  word_t stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stage_q <= '0;
    else if (pre_go) stage_q <= pre_val;
    else if (wr_en)  stage_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_q <= '0;
    else if (pre_go) dac_q <= pre_val;
    else if (upd_go) dac_q <= stage_q;
  end

  // R4/R6: the output register moves only on an update or a preset
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_go || pre_go) |=> $stable(dac_q));
  // R5: an update copies the staged word
  a_r5_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && !pre_go) |=> dac_q == $past(stage_q));
  // R4: a write puts the serial word into staging
  a_r4_stage_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pre_go) |=> stage_q == $past(wr_data));
  // R8/R9/R10: a preset drives both registers to the preset code
  a_r10_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |=> (dac_q == $past(pre_val)) && (stage_q == $past(pre_val)));
endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_din,
  input  logic                     ser_sel_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     ld_n,
  input  logic                     upd,
  input  logic                     preset,
  input  logic                     preset_mid,
  output logic [NUM_CH*WORD_W-1:0] dac_out
);
  localparam logic [PIN_W-1:0] PIN_RST =
    (PIN_W'(1) << P_SEL) | (PIN_W'(1) << P_LD);

  logic [PIN_W-1:0] pin_raw, pin_q;
  assign pin_raw = {addr, preset_mid, preset, upd, ld_n, ser_sel_n, ser_din, ser_clk};

  dacif_sync #(.N(PIN_W), .STAGES(SYNC_LEN), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_q));

  // previous levels of the edge-sensitive pins
  logic sclk_d, ld_d, upd_d, pre_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ld_d   <= 1'b1;
      upd_d  <= 1'b0;
      pre_d  <= 1'b0;
    end else begin
      sclk_d <= pin_q[P_SCLK];
      ld_d   <= pin_q[P_LD];
      upd_d  <= pin_q[P_UPD];
      pre_d  <= pin_q[P_PRE];
    end
  end

  logic sclk_rise, ld_fall, upd_rise, pre_rise, sel_act;
  assign sclk_rise = pin_q[P_SCLK] & ~sclk_d;
  assign ld_fall   = ~pin_q[P_LD] & ld_d;
  assign upd_rise  = pin_q[P_UPD] & ~upd_d;
  assign pre_rise  = pin_q[P_PRE] & ~pre_d;
  assign sel_act   = ~pin_q[P_SEL];

  // qualified events, preset has top priority
  logic shift_go, load_go, upd_go, pre_go;
  assign pre_go   = pre_rise;
  assign shift_go = sclk_rise & sel_act;
  assign load_go  = ld_fall & sel_act & ~pre_go;
  assign upd_go   = upd_rise & ~sel_act & pin_q[P_LD] & ~pre_go;

  word_t ser_word, pre_val;
  assign pre_val = preset_code(pin_q[P_MID]);

  dacif_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_go),
    .bit_in(pin_q[P_DIN]), .word_q(ser_word));

  logic [NUM_CH-1:0] wr_en;
  assign wr_en = load_go ? ch_decode(pin_q[P_ADDR +: ADDR_W]) : '0;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    word_t ch_q;
    dacif_chan u_chan (
      .clk(clk), .rst_n(rst_n), .pre_go(pre_go), .pre_val(pre_val),
      .wr_en(wr_en[k]), .wr_data(ser_word), .upd_go(upd_go), .dac_q(ch_q));
    assign dac_out[k*WORD_W +: WORD_W] = ch_q;
  end

  // R4: at most one staging register is written at a time
  a_r4_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  // R11: no staging write while deselected
  a_r11_no_write_desel: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |-> wr_en == '0);
  // R6: an update never goes through while selected
  a_r6_upd_needs_desel: assert property (@(posedge clk) disable iff (!rst_n)
    sel_act |=> $stable(dac_out) || $past(pre_go));
endmodule

// File: tb/sim_dacif_top.sv
module sim_dacif_top;
  import dacif_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_sel_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic ld_n = 1'b1, upd = 1'b0, preset = 1'b0, preset_mid = 1'b0;
  logic [NUM_CH*WORD_W-1:0] dac_out;

  always #2.5 clk = ~clk;

  dacif_top u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_sel_n(ser_sel_n), .addr(addr), .ld_n(ld_n), .upd(upd), .preset(preset),
    .preset_mid(preset_mid), .dac_out(dac_out));

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] m_stage [NUM_CH];
  logic [15:0] m_out   [NUM_CH];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NUM_CH; k++) check(tag, dac_out[16*k +: 16], m_out[k]);
  endtask

  // send n bits of v, MSB of the n first; select is left as it is
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = v[i]; tick(4);
      ser_clk = 1'b1; tick(4);
      ser_clk = 1'b0;
    end
    tick(4);
  endtask

  task automatic pulse_load(input int ch);
    addr = ADDR_W'(ch); tick(4);
    ld_n = 1'b0; tick(6);
    ld_n = 1'b1; tick(6);
  endtask

  task automatic write_ch(input int ch, input logic [15:0] w);
    ser_sel_n = 1'b0; tick(4);
    send_bits({16'h0, w}, 16);
    pulse_load(ch);
    ser_sel_n = 1'b1; tick(6);
    m_stage[ch] = w;
  endtask

  task automatic pulse_update;
    upd = 1'b1; tick(6);
    upd = 1'b0; tick(6);
  endtask

  task automatic commit;
    for (int k = 0; k < NUM_CH; k++) m_out[k] = m_stage[k];
  endtask

  task automatic do_preset(input logic mid);
    preset_mid = mid; tick(6);
    preset = 1'b1; tick(6);
    preset = 1'b0; tick(6);
    for (int k = 0; k < NUM_CH; k++) begin
      m_stage[k] = mid ? 16'h8000 : 16'h0000;
      m_out[k]   = m_stage[k];
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NUM_CH; k++) begin m_stage[k] = '0; m_out[k] = '0; end
    tick(4);
    rst_n = 1'b1; tick(6);
    check_all("R1 reset state");

    // R4/R5 sweep: every channel, several patterns
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < NUM_CH; k++) begin
        logic [15:0] w;
        case (r)
          0: w = 16'h0001 << (k * 4 + 1);
          1: w = ~(16'h0001 << (k * 3));
          2: w = 16'hA5C3 ^ (16'h1111 * (k + 1));
          default: w = 16'(k * 16'h3C01 + r);
        endcase
        write_ch(k, w);
        check_all("R4 output held after load");
      end
      pulse_update; commit;
      check_all("R5 all channels updated");
    end

    // R2: over-long word keeps the last 16 bits
    ser_sel_n = 1'b0; tick(4);
    send_bits(32'h00F_1234 | 32'h00A00000, 24);
    pulse_load(2);
    ser_sel_n = 1'b1; tick(6);
    m_stage[2] = 16'h1234;
    pulse_update; commit;
    check("R2 last 16 bits MSB first", dac_out[32 +: 16], 16'h1234);

    // R3: clock edges while deselected do not shift
    write_ch(0, 16'h6E2B);
    send_bits(32'h0000_FFFF, 16);
    ser_sel_n = 1'b0; tick(4);
    pulse_load(1);
    ser_sel_n = 1'b1; tick(6);
    m_stage[1] = 16'h6E2B;
    pulse_update; commit;
    check("R3 deselected clocks ignored", dac_out[16 +: 16], 16'h6E2B);

    // R6: update with select low, then with load low
    write_ch(3, 16'hBEEF);
    ser_sel_n = 1'b0; tick(4);
    pulse_update;
    ser_sel_n = 1'b1; tick(6);
    check("R6 update ignored while selected", dac_out[48 +: 16], m_out[3]);
    ld_n = 1'b0; tick(6);
    pulse_update;
    ld_n = 1'b1; tick(6);
    check("R6 update ignored while load low", dac_out[48 +: 16], m_out[3]);
    pulse_update; commit;
    check("R5 update after qualified edge", dac_out[48 +: 16], 16'hBEEF);

    // R11: load strobe while deselected writes nothing
    ser_sel_n = 1'b0; tick(4);
    send_bits(32'h0000_0F0F, 16);
    ser_sel_n = 1'b1; tick(4);
    pulse_load(0);
    pulse_update; commit;
    check_all("R11 deselected load ignored");

    // R7: update held high; a later write stays staged
    upd = 1'b1; tick(6);
    write_ch(2, 16'h7A7A);
    check("R7 held update does not copy", dac_out[32 +: 16], m_out[2]);
    upd = 1'b0; tick(6);
    pulse_update; commit;
    check("R7 next update edge copies", dac_out[32 +: 16], 16'h7A7A);

    // R8: preset to zero-scale, staging also cleared
    do_preset(1'b0);
    check_all("R8 preset zero outputs");
    pulse_update;
    check_all("R8 preset zero staging");

    // R9: preset to mid-scale
    write_ch(1, 16'h1357);
    do_preset(1'b1);
    check_all("R9 preset mid outputs");
    pulse_update;
    check_all("R9 preset mid staging");

    // R10: preset and update edges together
    for (int k = 0; k < NUM_CH; k++) write_ch(k, 16'h0F00 + 16'(k));
    preset_mid = 1'b0; tick(6);
    preset = 1'b1; upd = 1'b1; tick(6);
    preset = 1'b0; upd = 1'b0; tick(6);
    for (int k = 0; k < NUM_CH; k++) begin m_stage[k] = '0; m_out[k] = '0; end
    check_all("R10 preset wins over update");

    done = 1'b1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule